// File: doc/BRIEF.md
# Serial Flash Read Line Cache

This block sits between a memory-mapped read port and the fetch engine of an external serial flash. It keeps a single line of flash data together with the base address of that line. Every bus read is compared with the held line. When the read falls inside a valid line, the requested 32-bit word comes back in the same cycle. When it does not, the block builds one fetch transaction from its read-configuration register: the command opcode, the aligned start address and the byte count. It then accepts the returned bytes into the line and answers the stalled read once the line is complete.

The line length is set in software through a size code in the read-configuration register. It ranges from 4 to 64 bytes, always a power of two, and the line base is the request address aligned down to that length. For the whole of a refill the block raises a bus-access status bit, and the busy status bit follows it. Any write to the read-configuration register discards the held line. A write that lands while a refill is in flight lets that refill finish, but the refilled line is not kept. The read that is still waiting is then fetched again with the new settings.

Top module: `flash_line_cache`

## Requirements
- R1: After reset no line is valid: `bus_ready`, `fetch_req_valid`, `stat_bus_acc` and `stat_busy` are low, and the first read always misses.
- R2: A read whose address lies in the valid held line gets `bus_ready` in the cycle it is presented, with no fetch. `bus_rdata` is the word at byte offset `addr mod size` rounded down to a multiple of 4, little-endian: the byte at the lowest address sits in bits 7:0.
- R3: A read that misses raises one fetch request with `fetch_addr` equal to the request address aligned down to the line size, `fetch_opcode` equal to the configured opcode, and address, length and opcode held stable until `fetch_req_ready`.
- R4: Size code c in `cfg_size_code` selects a line of 4·2^c bytes for c = 0 to 4, and 64 bytes for codes 5 to 7. `fetch_len` carries that byte count.
- R5: After the request handshake the block accepts one byte per cycle with `fetch_rsp_valid`, storing the k-th byte at line offset k. It stops after exactly `fetch_len` bytes and issues no other fetch request while bytes are outstanding.
- R6: A missed read is stalled with `bus_ready` low during the whole refill. It completes with the correct word once the last byte has been taken.
- R7: `stat_bus_acc` is high from the cycle after a miss until the last byte is taken, and `stat_busy` is high whenever `stat_bus_acc` is high.
- R8: A write to the read-configuration register (`cfg_we`) invalidates the held line, so the next read misses even at the same address with the same settings.
- R9: A configuration write during a refill lets that refill finish but leaves the line invalid. The pending read is then refetched with the new opcode and size.
- R10: Only one line is held: a miss to another line replaces it, and a later read of the old line misses again.
- R11: Bits 1:0 of `bus_addr` do not affect hit detection or the returned word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe of the read-configuration register |
| cfg_opcode | input | 8 | Flash read command used for refills |
| cfg_size_code | input | CODE_W (3) | Line size code |
| bus_req | input | 1 | Read request, held until `bus_ready` |
| bus_addr | input | ADDR_W (32) | Byte address of the read |
| bus_ready | output | 1 | Read completes this cycle |
| bus_rdata | output | 32 | Read data word |
| fetch_req_valid | output | 1 | Fetch transaction request |
| fetch_req_ready | input | 1 | Fetch engine accepts the request |
| fetch_addr | output | ADDR_W (32) | Aligned start address of the fetch |
| fetch_len | output | LINE_MAX_LOG2+1 (7) | Byte count of the fetch |
| fetch_opcode | output | 8 | Command opcode of the fetch |
| fetch_rsp_valid | input | 1 | One fetched byte is valid |
| fetch_rsp_byte | input | 8 | Fetched byte |
| stat_bus_acc | output | 1 | Bus-triggered refill in progress |
| stat_busy | output | 1 | Module busy |

## Verification
The assertions assume that a requester keeps `bus_req` and `bus_addr` steady until `bus_ready`. They also assume that the fetch engine sends bytes only after accepting a request and never sends more than the requested count. The stimulus holds each read until it completes. Its flash model counts down exactly the captured length and inserts random idle cycles between bytes and before accepting requests. Configuration writes are only issued between reads or, in one directed case, in the middle of a refill, where the design is required to handle them.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_FILL = 2'd2
   } fill_state_t;

   // line size exponent from the size code, clamped at the storage limit
   function automatic int unsigned code_to_log2(int unsigned code, int unsigned max_log2);
      int unsigned l;
      l = code + 2;
      return (l > max_log2) ? max_log2 : l;
   endfunction

endpackage

// File: rtl/flc_cfg_reg.sv
`timescale 1ns/1ps
module flc_cfg_reg #(
   parameter int ADDR_W        = 32,
   parameter int CODE_W        = 3,
   parameter int LINE_MAX_LOG2 = 6,
   parameter int LOG_W         = $clog2(LINE_MAX_LOG2 + 1),
   parameter logic [7:0] RESET_OP = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_opcode,
   input  logic [CODE_W-1:0] cfg_size_code,
   output logic [7:0]        op_q,
   output logic [LOG_W-1:0]  size_log2,
   output logic [ADDR_W-1:0] line_mask
);
   import flc_pkg::*;

   logic [CODE_W-1:0] code_q;

   generate
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
         $error("flc_cfg_reg: CODE_W out of range");
      end
      if (ADDR_W <= LINE_MAX_LOG2) begin : g_bad_addr
         $error("flc_cfg_reg: ADDR_W must exceed LINE_MAX_LOG2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= RESET_OP;
         code_q <= '0;
      end else if (cfg_we) begin
         op_q   <= cfg_opcode;
         code_q <= cfg_size_code;
      end
   end

   always_comb begin
      size_log2 = LOG_W'(code_to_log2(32'(code_q), LINE_MAX_LOG2));
      line_mask = ~({ADDR_W{1'b1}} << size_log2);
   end

endmodule

// File: rtl/flc_line_tag.sv
`timescale 1ns/1ps
module flc_line_tag #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              set,
   input  logic [ADDR_W-1:0] set_base,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] line_mask,
   output logic              hit,
   output logic              line_valid
);

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_valid <= 1'b0;
         base_q     <= '0;
      end else if (clr) begin
         line_valid <= 1'b0;
      end else if (set) begin
         line_valid <= 1'b1;
         base_q     <= set_base;
      end
   end

   always_comb hit = line_valid && ((req_addr & ~line_mask) == base_q);

   // R8
   tag_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> !line_valid);

endmodule

// File: rtl/flc_line_store.sv
`timescale 1ns/1ps
module flc_line_store #(
   parameter int LINE_MAX_LOG2 = 6,
   parameter int WIDX_W        = LINE_MAX_LOG2 - 2
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [LINE_MAX_LOG2-1:0] wr_idx,
   input  logic [7:0]               wr_byte,
   input  logic [WIDX_W-1:0]        rd_word_idx,
   output logic [31:0]              rd_word
);
   localparam int BYTES = 1 << LINE_MAX_LOG2;
   localparam int WORDS = BYTES / 4;

   generate
      if (LINE_MAX_LOG2 < 3 || LINE_MAX_LOG2 > 10) begin : g_bad_size
         $error("flc_line_store: LINE_MAX_LOG2 must be 3..10");
      end
   endgenerate

   logic [7:0]  mem   [BYTES];
   logic [31:0] words [WORDS];

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == LINE_MAX_LOG2'(b))) mem[b] <= wr_byte;
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign words[w] = {mem[4*w+3], mem[4*w+2], mem[4*w+1], mem[4*w]};
   end

   assign rd_word = words[rd_word_idx];

endmodule

// File: rtl/flc_fill_ctrl.sv
`timescale 1ns/1ps
module flc_fill_ctrl #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 7,
   parameter int LOG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              hit,
   input  logic [ADDR_W-1:0] line_mask,
   input  logic [LOG_W-1:0]  size_log2,
   input  logic [7:0]        cfg_op,
   input  logic              cfg_we,
   output logic              fetch_req_valid,
   input  logic              fetch_req_ready,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [LEN_W-1:0]  fetch_len,
   output logic [7:0]        fetch_opcode,
   input  logic              fetch_rsp_valid,
   input  logic [7:0]        fetch_rsp_byte,
   output logic              wr_en,
   output logic [LEN_W-2:0]  wr_idx,
   output logic [7:0]        wr_byte,
   output logic              miss_start,
   output logic              fill_keep,
   output logic              active
);
   import flc_pkg::*;

   fill_state_t       state_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W-1:0] base_q;
   logic [7:0]        op_q;
   logic              inv_q;
   logic              last_beat;

   always_comb begin
      miss_start      = (state_q == FS_IDLE) && bus_req && !hit;
      last_beat       = (state_q == FS_FILL) && fetch_rsp_valid && (cnt_q == len_q - LEN_W'(1));
      fill_keep       = last_beat && !inv_q && !cfg_we;
      active          = (state_q != FS_IDLE);
      fetch_req_valid = (state_q == FS_REQ);
      fetch_addr      = base_q;
      fetch_len       = len_q;
      fetch_opcode    = op_q;
      wr_en           = (state_q == FS_FILL) && fetch_rsp_valid;
      wr_idx          = cnt_q[LEN_W-2:0];
      wr_byte         = fetch_rsp_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         cnt_q   <= '0;
         len_q   <= '0;
         base_q  <= '0;
         op_q    <= '0;
         inv_q   <= 1'b0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (miss_start) begin
                  state_q <= FS_REQ;
                  base_q  <= bus_addr & ~line_mask;
                  len_q   <= LEN_W'(1) << size_log2;
                  op_q    <= cfg_op;
                  inv_q   <= cfg_we;
               end
            end
            FS_REQ: begin
               if (cfg_we) inv_q <= 1'b1;
               if (fetch_req_ready) begin
                  state_q <= FS_FILL;
                  cnt_q   <= '0;
               end
            end
            FS_FILL: begin
               if (cfg_we) inv_q <= 1'b1;
               if (fetch_rsp_valid) begin
                  cnt_q <= cnt_q + LEN_W'(1);
                  if (last_beat) state_q <= FS_IDLE;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   // R5
   fill_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FS_FILL) |-> (cnt_q < len_q));

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req_valid && !fetch_req_ready) |=>
         (fetch_req_valid && $stable(fetch_addr) && $stable(fetch_len) && $stable(fetch_opcode)));

endmodule

// File: rtl/flash_line_cache.sv
`timescale 1ns/1ps
module flash_line_cache #(
   parameter int ADDR_W        = 32,
   parameter int CODE_W        = 3,
   parameter int LINE_MAX_LOG2 = 6,
   parameter logic [7:0] RESET_OP = 8'h03
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [7:0]               cfg_opcode,
   input  logic [CODE_W-1:0]        cfg_size_code,
   input  logic                     bus_req,
   input  logic [ADDR_W-1:0]        bus_addr,
   output logic                     bus_ready,
   output logic [31:0]              bus_rdata,
   output logic                     fetch_req_valid,
   input  logic                     fetch_req_ready,
   output logic [ADDR_W-1:0]        fetch_addr,
   output logic [LINE_MAX_LOG2:0]   fetch_len,
   output logic [7:0]               fetch_opcode,
   input  logic                     fetch_rsp_valid,
   input  logic [7:0]               fetch_rsp_byte,
   output logic                     stat_bus_acc,
   output logic                     stat_busy
);
   localparam int LEN_W  = LINE_MAX_LOG2 + 1;
   localparam int LOG_W  = $clog2(LINE_MAX_LOG2 + 1);
   localparam int WIDX_W = LINE_MAX_LOG2 - 2;

   logic [7:0]               op_q;
   logic [LOG_W-1:0]         size_log2;
   logic [ADDR_W-1:0]        line_mask;
   logic                     hit;
   logic                     line_valid;
   logic                     miss_start;
   logic                     fill_keep;
   logic                     active;
   logic                     wr_en;
   logic [LEN_W-2:0]         wr_idx;
   logic [7:0]               wr_byte;
   logic [WIDX_W-1:0]        rd_word_idx;

   flc_cfg_reg #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .LINE_MAX_LOG2(LINE_MAX_LOG2),
      .LOG_W(LOG_W), .RESET_OP(RESET_OP)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opcode(cfg_opcode),
      .cfg_size_code(cfg_size_code), .op_q(op_q), .size_log2(size_log2),
      .line_mask(line_mask)
   );

   flc_line_tag #(.ADDR_W(ADDR_W)) u_tag (
      .clk(clk), .rst_n(rst_n), .clr(cfg_we | miss_start), .set(fill_keep),
      .set_base(fetch_addr), .req_addr(bus_addr), .line_mask(line_mask),
      .hit(hit), .line_valid(line_valid)
   );

   flc_fill_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LOG_W(LOG_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
      .hit(hit), .line_mask(line_mask), .size_log2(size_log2), .cfg_op(op_q),
      .cfg_we(cfg_we), .fetch_req_valid(fetch_req_valid),
      .fetch_req_ready(fetch_req_ready), .fetch_addr(fetch_addr),
      .fetch_len(fetch_len), .fetch_opcode(fetch_opcode),
      .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_byte(fetch_rsp_byte),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
      .miss_start(miss_start), .fill_keep(fill_keep), .active(active)
   );

   assign rd_word_idx = bus_addr[LINE_MAX_LOG2-1:2] & line_mask[LINE_MAX_LOG2-1:2];

   flc_line_store #(.LINE_MAX_LOG2(LINE_MAX_LOG2), .WIDX_W(WIDX_W)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
      .rd_word_idx(rd_word_idx), .rd_word(bus_rdata)
   );

   assign bus_ready    = bus_req && hit && !active;
   assign stat_bus_acc = active;
   assign stat_busy    = active;

   // R7
   acc_rise_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_bus_acc) |-> $past(bus_req && !bus_ready));

   // R8
   cfg_write_forces_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_we) |-> !bus_ready);

   // R4
   fetch_len_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_valid |-> ($countones(fetch_len) == 1 && fetch_len >= LEN_W'(4)));

   // R3
   fetch_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_valid |-> ((fetch_addr & (ADDR_W'(fetch_len) - ADDR_W'(1))) == '0));

   // R6
   no_ready_while_filling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_rsp_valid && stat_bus_acc) |-> !line_valid);

endmodule

// File: tb/flash_line_cache_bench.sv
`timescale 1ns/1ps
module flash_line_cache_bench;
   localparam int ADDR_W = 32;
   localparam int CODE_W = 3;
   localparam int LMAX   = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [7:0]        cfg_opcode = '0;
   logic [CODE_W-1:0] cfg_size_code = '0;
   logic              bus_req = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_ready;
   logic [31:0]       bus_rdata;
   logic              fetch_req_valid;
   logic              fetch_req_ready = 1'b0;
   logic [ADDR_W-1:0] fetch_addr;
   logic [LMAX:0]     fetch_len;
   logic [7:0]        fetch_opcode;
   logic              fetch_rsp_valid = 1'b0;
   logic [7:0]        fetch_rsp_byte = '0;
   logic              stat_bus_acc;
   logic              stat_busy;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   int          fetch_count = 0;
   logic [31:0] last_faddr = '0;
   int          last_flen = 0;
   logic [7:0]  last_fop = '0;
   int          beats_left = 0;
   logic [31:0] cur_addr = '0;

   bit          m_valid = 0;
   logic [31:0] m_base = '0;
   int          m_size = 4;
   logic [7:0]  m_op = 8'h03;

   flash_line_cache u_flash_line_cache (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opcode(cfg_opcode),
      .cfg_size_code(cfg_size_code), .bus_req(bus_req), .bus_addr(bus_addr),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
      .fetch_addr(fetch_addr), .fetch_len(fetch_len), .fetch_opcode(fetch_opcode),
      .fetch_rsp_valid(fetch_rsp_valid), .fetch_rsp_byte(fetch_rsp_byte),
      .stat_bus_acc(stat_bus_acc), .stat_busy(stat_busy)
   );

   always #2 clk = ~clk;

   function automatic logic [7:0] fbyte(logic [31:0] a);
      return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [31:0] exp_word(logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return {fbyte(w + 3), fbyte(w + 2), fbyte(w + 1), fbyte(w)};
   endfunction

   function automatic int exp_size(int code);
      return (code >= 4) ? 64 : (4 << code);
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // flash model: accepts requests with random delay, returns bytes with random gaps
   initial begin
      forever begin
         @(negedge clk);
         fetch_rsp_valid = 1'b0;
         if (beats_left == 0) begin
            fetch_req_ready = (($urandom % 4) != 0);
            if (fetch_req_valid && fetch_req_ready) begin
               last_faddr = fetch_addr;
               last_flen  = int'(fetch_len);
               last_fop   = fetch_opcode;
               beats_left = int'(fetch_len);
               cur_addr   = fetch_addr;
               fetch_count++;
            end
         end else begin
            fetch_req_ready = 1'b0;
            // R7 status during refill; R6 read stalled; R5 no new request
            check(stat_bus_acc && stat_busy, "R7 status during refill",
                  {30'd0, stat_bus_acc, stat_busy}, 32'd3);
            check(!bus_ready, "R6 ready during refill", {31'd0, bus_ready}, 32'd0);
            check(!fetch_req_valid, "R5 request while bytes outstanding",
                  {31'd0, fetch_req_valid}, 32'd0);
            if (($urandom % 3) != 0) begin
               fetch_rsp_valid = 1'b1;
               fetch_rsp_byte  = fbyte(cur_addr);
               cur_addr        = cur_addr + 1;
               beats_left--;
            end
         end
      end
   end

   task automatic cfg_write(logic [7:0] op, int code);
      @(negedge clk);
      cfg_we        = 1'b1;
      cfg_opcode    = op;
      cfg_size_code = CODE_W'(code);
      @(posedge clk);
      #1 cfg_we = 1'b0;
      m_valid = 0;
      m_op    = op;
      m_size  = exp_size(code);
   endtask

   task automatic do_read(logic [31:0] addr, output logic [31:0] data,
                          output int lat, output int nf);
      int f0;
      f0 = fetch_count;
      @(negedge clk);
      bus_req  = 1'b1;
      bus_addr = addr;
      lat = 0;
      #1;
      while (!bus_ready) begin
         @(negedge clk);
         #1;
         lat++;
      end
      data = bus_rdata;
      @(posedge clk);
      #1 bus_req = 1'b0;
      nf = fetch_count - f0;
   endtask

   task automatic read_check(logic [31:0] addr);
      logic [31:0] d;
      logic [31:0] base;
      int lat;
      int nf;
      bit exp_hit;
      base    = addr & ~(m_size - 1);
      exp_hit = m_valid && (base == m_base);
      do_read(addr, d, lat, nf);
      check(d == exp_word(addr), "R2 read data", d, exp_word(addr));
      if (exp_hit) begin
         check(lat == 0, "R2 hit latency", lat, 0);
         check(nf == 0, "R2 hit without fetch", nf, 0);
      end else begin
         check(nf == 1, "R5 one fetch per miss", nf, 1);
         check(lat > 0, "R6 miss stalls", lat, 1);
         check(last_faddr == base, "R3 fetch address", last_faddr, base);
         check(last_flen == m_size, "R4 fetch length", last_flen, m_size);
         check(last_fop == m_op, "R3 fetch opcode", last_fop, m_op);
         m_valid = 1;
         m_base  = base;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int lat;
      int nf;
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(!bus_ready && !fetch_req_valid && !stat_bus_acc && !stat_busy,
            "R1 reset outputs",
            {28'd0, bus_ready, fetch_req_valid, stat_bus_acc, stat_busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!stat_busy, "R1 idle after reset", {31'd0, stat_busy}, 32'd0);

      // R1 first read misses, then hits (R2), low bits ignored (R11)
      read_check(32'h100);
      check(fetch_count == 1, "R1 first read fetched", fetch_count, 1);
      read_check(32'h100);
      read_check(32'h101);
      do_read(32'h103, d, lat, nf);
      check(lat == 0 && nf == 0, "R11 low bits hit", lat, 0);
      check(d == exp_word(32'h100), "R11 low bits data", d, exp_word(32'h100));

      // 32-byte line (R4 code 3)
      cfg_write(8'h0B, 3);
      read_check(32'h1024);
      read_check(32'h103C);
      read_check(32'h1020);

      // R10 single line eviction
      read_check(32'h2000);
      do_read(32'h1020, d, lat, nf);
      check(nf == 1, "R10 old line misses", nf, 1);
      m_valid = 1; m_base = 32'h1020;

      // R8 config rewrite with same values invalidates
      cfg_write(8'h0B, 3);
      do_read(32'h1020, d, lat, nf);
      check(nf == 1, "R8 miss after cfg write", nf, 1);
      check(d == exp_word(32'h1020), "R8 data after refetch", d, exp_word(32'h1020));
      m_valid = 1; m_base = 32'h1020;

      // R4 codes clamp to 64 bytes
      cfg_write(8'h6B, 7);
      read_check(32'h3010);
      check(last_flen == 64, "R4 code 7 length", last_flen, 64);
      read_check(32'h303C);
      cfg_write(8'h6C, 0);
      read_check(32'h3010);
      check(last_flen == 4, "R4 code 0 length", last_flen, 4);

      // R9 config write during refill
      cfg_write(8'h3B, 4);
      fork
         do_read(32'h4008, d, lat, nf);
         begin
            wait (beats_left == 20);
            cfg_write(8'hEB, 1);
         end
      join
      check(nf == 2, "R9 refetch after mid-fill write", nf, 2);
      check(last_flen == 8, "R9 new length", last_flen, 8);
      check(last_fop == 8'hEB, "R9 new opcode", last_fop, 8'hEB);
      check(d == exp_word(32'h4008), "R9 data", d, exp_word(32'h4008));
      m_valid = 1; m_base = 32'h4008; m_size = 8; m_op = 8'hEB;
      read_check(32'h400C);

      // random phase
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 16) == 0) begin
            cfg_write(8'($urandom), int'($urandom % 8));
         end else begin
            read_check(32'h5000 + ($urandom % 512));
         end
      end

      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule